// File: doc/BRIEF.md
# External Interrupt Sensitivity Unit

This block turns the levels on a group of input pins into a single interrupt request for one vector. Each pin may be switched in or out as a source. A pin that is disabled, or whose port is configured as an output, is left out. The remaining pins are combined with a logical AND. Because of this, one enabled pin held low pulls the combined line low, and any other enabled pin cannot then raise a request.

The combined line is resynchronised to the clock. It is then judged by a sensitivity stage that a 2-bit code selects. Four choices exist: a low level together with falling edges, falling edges alone, rising edges alone, or both edges.

Detected edges are kept in a pending latch. Entry into the service routine clears the latch, and so does any change of the sensitivity code. A global mask holds the request back from the core. While the mask is set, the pending state is kept.

Top module: `exti_sense_unit`

## Requirements
- R1: A pin takes part in the combined line only when its enable bit is 1 and its output-configuration bit is 0. Taking part means that the combined line is the AND of the levels of all such pins. When no pin takes part, the combined line is high.
- R2: With code 2'b00, which is the reset value, a falling edge of the combined line is latched. In addition, the pending flag is 1 for as long as the resynchronised combined line is low, and this holds even after an acknowledge.
- R3: With code 2'b10, only a falling edge of the combined line sets the pending flag. A rising edge does not set it.
- R4: With code 2'b01, only a rising edge of the combined line sets the pending flag. A falling edge does not set it.
- R5: With code 2'b11, a rising edge and a falling edge of the combined line both set the pending flag.
- R6: While any enabled input pin is low, a rising level on another enabled pin raises no request, even in rising-edge mode. The request appears once the last low pin rises.
- R7: A 1 on `isr_ack` clears the latched request at the next clock edge. The exception is an edge detected in that same cycle: the latch then stays set.
- R8: Any change of `pol_code` clears the latched request at the next clock edge. Edges seen in that cycle are ignored.
- R9: `core_req` equals the pending flag while `glob_mask` is 0 and is 0 while `glob_mask` is 1. A latched request is kept through a masked period and is presented once the mask clears.
- R10: After reset, `pend_flag` and `core_req` are 0.
- R11: The combined line passes through a two-flop synchroniser, so an edge sets `pend_flag` at the third rising clock edge after the pin change and not before. The low level in mode 2'b00 shows at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_lvl | input | NUM_PINS | Pin levels |
| pin_int_en | input | NUM_PINS | Per-pin interrupt enable |
| pin_is_out | input | NUM_PINS | Per-pin output configuration (1 = output, excluded) |
| pol_code | input | 2 | Sensitivity code: 00 low+fall, 10 fall, 01 rise, 11 both |
| glob_mask | input | 1 | Global interrupt mask (1 = blocked) |
| isr_ack | input | 1 | Service-routine entry acknowledge |
| pend_flag | output | 1 | Request pending (latched edge or active low level) |
| core_req | output | 1 | Request presented to the core |

## Verification
The combiner is swept over every combination of enable, output-configuration and level pattern for four pins. In mode 2'b00, after an acknowledge, the pending flag shows the inverse of the combined line, so any wrong pin that takes part or any polarity slip in the AND shows up.

Each sensitivity code is then driven through all four transitions of the combined line: stay low, stay high, fall and rise. This separates the modes by which transitions latch, and it checks the exact synchroniser latency.

Directed sequences cover a pin held low that blocks a rise, an acknowledge that arrives together with a new edge, a code change that clears the latch, and a request kept while masked.

// File: rtl/exti_pkg.sv
// Package: shared sensitivity-mode type for the external interrupt unit.
package exti_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW_FALL = 2'b00,
        SENSE_RISE     = 2'b01,
        SENSE_FALL     = 2'b10,
        SENSE_BOTH     = 2'b11
    } sense_e;

endpackage

// File: rtl/exti_pin_combine.sv
// Module: exti_pin_combine
// Builds the combined source line. A pin takes part only when it is enabled
// as an interrupt source and not configured as an output. A pin that does not
// take part reads as 1, so it cannot pull the AND low.
// Assumes: purely combinational; the pin levels may be asynchronous.
module exti_pin_combine #(
    parameter int NUM_PINS = 4
) (
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_int_en,
    input  logic [NUM_PINS-1:0] pin_is_out,
    output logic                comb_raw
);

    logic [NUM_PINS-1:0] term;

    // Per-pin term: the pin level when the pin takes part, else a neutral 1.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_term
        assign term[g] = (pin_int_en[g] & ~pin_is_out[g]) ? pin_lvl[g] : 1'b1;
    end

    // AND of all terms.
    assign comb_raw = &term;

endmodule

// File: rtl/exti_sync.sv
// Module: exti_sync
// A chain of SYNC_STAGES flops that brings the combined line into the clock
// domain. It resets to 1, the idle level, so that no false falling edge
// appears after reset.
// Assumes: SYNC_STAGES >= 2.
module exti_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: sample the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= d_async;
            end
        end else begin : g_next
            // Later stages: settle the value of the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_sync = chain[LAST];

endmodule

// File: rtl/exti_edge_sense.sv
// Module: exti_edge_sense
// Judges the synchronised combined line against the selected sensitivity. It
// gives a one-cycle edge hit and a level term. It also flags a change of the
// sensitivity code, and it suppresses edge hits in the cycle of that change.
// Assumes: comb_s is already synchronous to clk.
module exti_edge_sense
    import exti_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       comb_s,
    input  logic [1:0] pol_code,
    output logic       edge_hit,
    output logic       level_req,
    output logic       pol_chg
);

    logic   comb_q;
    logic   fall;
    logic   rise;
    logic   hit;
    sense_e mode;
    logic [1:0] pol_q;

    // Keep the last line value and the last sensitivity code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comb_q <= 1'b1;
            pol_q  <= 2'b00;
        end else begin
            comb_q <= comb_s;
            pol_q  <= pol_code;
        end
    end

    // Pick the edges that the current code selects.
    always_comb begin
        mode = sense_e'(pol_code);
        fall = comb_q & ~comb_s;
        rise = ~comb_q & comb_s;
        case (mode)
            SENSE_LOW_FALL: hit = fall;
            SENSE_FALL:     hit = fall;
            SENSE_RISE:     hit = rise;
            SENSE_BOTH:     hit = fall | rise;
            default:        hit = 1'b0;
        endcase
    end

    assign pol_chg   = (pol_code != pol_q);
    assign edge_hit  = hit & ~pol_chg;
    assign level_req = (mode == SENSE_LOW_FALL) & ~comb_s;

endmodule

// File: rtl/exti_req_latch.sv
// Module: exti_req_latch
// Holds a detected edge until it is serviced. A code change clears it first.
// A new edge comes next and wins over a simultaneous acknowledge.
// Assumes: all inputs synchronous to clk.
module exti_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic pol_chg,
    input  logic isr_ack,
    output logic lat_q
);

    // Pending latch update, in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n)        lat_q <= 1'b0;
        else if (pol_chg)  lat_q <= 1'b0;
        else if (edge_hit) lat_q <= 1'b1;
        else if (isr_ack)  lat_q <= 1'b0;
    end

endmodule

// File: rtl/exti_sense_unit.sv
// Module: exti_sense_unit (top)
// Request builder for one external interrupt vector. The flow is:
// pin combiner -> synchroniser -> sensitivity stage -> pending latch.
// The output is masked by the global interrupt mask.
// Assumes: one clock domain; the pin levels may be asynchronous.
module exti_sense_unit #(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_int_en,
    input  logic [NUM_PINS-1:0] pin_is_out,
    input  logic [1:0]          pol_code,
    input  logic                glob_mask,
    input  logic                isr_ack,
    output logic                pend_flag,
    output logic                core_req
);

    logic comb_raw;
    logic comb_s;
    logic edge_hit;
    logic level_req;
    logic pol_chg;
    logic lat_q;

    exti_pin_combine #(.NUM_PINS(NUM_PINS)) comb_i (
        .pin_lvl    (pin_lvl),
        .pin_int_en (pin_int_en),
        .pin_is_out (pin_is_out),
        .comb_raw   (comb_raw)
    );

    exti_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (comb_raw),
        .q_sync  (comb_s)
    );

    exti_edge_sense sense_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .comb_s    (comb_s),
        .pol_code  (pol_code),
        .edge_hit  (edge_hit),
        .level_req (level_req),
        .pol_chg   (pol_chg)
    );

    exti_req_latch latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_hit (edge_hit),
        .pol_chg  (pol_chg),
        .isr_ack  (isr_ack),
        .lat_q    (lat_q)
    );

    // Pending = latched edge or active low level; the core sees it unmasked only.
    assign pend_flag = lat_q | level_req;
    assign core_req  = pend_flag & ~glob_mask;

endmodule

// File: rtl/exti_sense_unit_chk.sv
// Module: exti_sense_unit_chk
// Property checker for exti_sense_unit, attached through bind. It observes
// the ports and the signals passed between the submodules.
module exti_sense_unit_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_int_en,
    input logic [NUM_PINS-1:0] pin_is_out,
    input logic [1:0]          pol_code,
    input logic                glob_mask,
    input logic                isr_ack,
    input logic                pend_flag,
    input logic                core_req,
    input logic                comb_raw,
    input logic                comb_s,
    input logic                edge_hit,
    input logic                pol_chg,
    input logic                lat_q
);

    // R1
    no_source_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_int_en & ~pin_is_out) == '0) |-> comb_raw);

    // R2
    low_level_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_code == 2'b00 && !comb_s) |-> pend_flag);

    // R3
    edge_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> lat_q);

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && isr_ack && !edge_hit && !pol_chg) |=> !lat_q);

    // R8
    code_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pol_chg |=> !lat_q);

    // R9
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && glob_mask && !isr_ack && !pol_chg) |=> lat_q);

    // R9
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_req |-> (!glob_mask && (lat_q || !comb_s)));

endmodule

bind exti_sense_unit exti_sense_unit_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_int_en (pin_int_en),
    .pin_is_out (pin_is_out),
    .pol_code   (pol_code),
    .glob_mask  (glob_mask),
    .isr_ack    (isr_ack),
    .pend_flag  (pend_flag),
    .core_req   (core_req),
    .comb_raw   (comb_raw),
    .comb_s     (comb_s),
    .edge_hit   (edge_hit),
    .pol_chg    (pol_chg),
    .lat_q      (lat_q)
);

// File: tb/exti_sense_unit_tb_top.sv
// Bench for exti_sense_unit: exhaustive combiner sweep, then a per-mode
// transition sweep, then directed corner cases.
module exti_sense_unit_tb_top;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = '1;
    logic [NP-1:0] pin_int_en = '0;
    logic [NP-1:0] pin_is_out = '0;
    logic [1:0]    pol_code = 2'b00;
    logic          glob_mask = 1'b0;
    logic          isr_ack = 1'b0;
    logic          pend_flag;
    logic          core_req;

    int total = 0;
    int bad = 0;

    exti_sense_unit #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pin_lvl),
        .pin_int_en (pin_int_en),
        .pin_is_out (pin_is_out),
        .pol_code   (pol_code),
        .glob_mask  (glob_mask),
        .isr_ack    (isr_ack),
        .pend_flag  (pend_flag),
        .core_req   (core_req)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Wait n rising edges, then land on the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ack_pulse();
        isr_ack = 1'b1;
        tick(1);
        isr_ack = 1'b0;
    endtask

    // Drive pins 0 and 1 (the only enabled ones) from a, then to b, and check the outcome.
    task automatic edge_case(input logic [1:0] mode, input logic a, input logic b);
        logic exp;
        pin_int_en = 4'b0011;
        pin_is_out = '0;
        pin_lvl    = {2'b11, a, a};
        pol_code   = mode;
        tick(4);
        ack_pulse();
        pin_lvl = {2'b11, b, b};
        case (mode)
            2'b10:   exp = a & ~b;
            2'b01:   exp = ~a & b;
            2'b11:   exp = a ^ b;
            default: exp = ~b;
        endcase
        tick(2);
        if (mode != 2'b00) chk("R11 no request before third edge", pend_flag, 0);
        tick(1);
        case (mode)
            2'b10:   chk("R3 falling-only mode", pend_flag, exp);
            2'b01:   chk("R4 rising-only mode", pend_flag, exp);
            2'b11:   chk("R5 both-edges mode", pend_flag, exp);
            default: chk("R2 low-level mode", pend_flag, exp);
        endcase
    endtask

    // Watchdog: counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R10 reset state
        chk("R10 pend after reset", pend_flag, 0);
        chk("R10 core_req after reset", core_req, 0);

        // R1 exhaustive combiner sweep in mode 00 (pend = inverse of combined line).
        for (int e = 0; e < 16; e++) begin
            for (int o = 0; o < 16; o++) begin
                for (int l = 0; l < 16; l++) begin
                    logic [NP-1:0] part;
                    logic          cexp;
                    pin_int_en = e[NP-1:0];
                    pin_is_out = o[NP-1:0];
                    pin_lvl    = l[NP-1:0];
                    part = e[NP-1:0] & ~o[NP-1:0];
                    cexp = &(l[NP-1:0] | ~part);
                    tick(3);
                    ack_pulse();
                    chk("R1 combined line", pend_flag, !cexp);
                end
            end
        end

        // R2-R5, R11: every mode over every transition.
        for (int m = 0; m < 4; m++) begin
            for (int t = 0; t < 4; t++) begin
                edge_case(m[1:0], t[1], t[0]);
            end
        end

        // R6: a low enabled pin blocks a rise in rising mode.
        pin_int_en = 4'b0011; pin_is_out = '0; pin_lvl = 4'b1100; pol_code = 2'b01;
        tick(4); ack_pulse();
        pin_lvl = 4'b1110;
        tick(3);
        chk("R6 rise blocked by low pin", pend_flag, 0);
        pin_lvl = 4'b1111;
        tick(3);
        chk("R6 rise after last low pin", pend_flag, 1);
        ack_pulse();

        // R7: acknowledge clears; edge in the ack cycle survives.
        pol_code = 2'b10; pin_lvl = 4'b1111;
        tick(4); ack_pulse();
        pin_lvl = 4'b1100;
        tick(3);
        chk("R7 latched fall", pend_flag, 1);
        chk("R9 core_req unmasked", core_req, 1);
        ack_pulse();
        chk("R7 ack clears", pend_flag, 0);
        pin_lvl = 4'b1111;
        tick(4); ack_pulse();
        pin_lvl = 4'b1100;
        tick(2);
        isr_ack = 1'b1;
        tick(1);
        isr_ack = 1'b0;
        chk("R7 edge wins over ack", pend_flag, 1);
        ack_pulse();
        chk("R7 second ack clears", pend_flag, 0);

        // R2: level request survives ack, drops when line rises.
        pol_code = 2'b00; pin_lvl = 4'b1111;
        tick(4); ack_pulse();
        pin_lvl = 4'b1100;
        tick(3);
        ack_pulse();
        chk("R2 level after ack", pend_flag, 1);
        chk("R2 core_req after ack", core_req, 1);
        pin_lvl = 4'b1111;
        tick(2);
        chk("R2 level released", pend_flag, 0);

        // R8: code change clears latch.
        pol_code = 2'b10;
        tick(4); ack_pulse();
        pin_lvl = 4'b1100;
        tick(3);
        chk("R8 latched before change", pend_flag, 1);
        pol_code = 2'b11;
        tick(1);
        chk("R8 code change clears", pend_flag, 0);

        // R9: masked request held, presented after unmask.
        pin_lvl = 4'b1111; glob_mask = 1'b1;
        tick(3);
        chk("R9 masked pend", pend_flag, 1);
        chk("R9 masked core_req", core_req, 0);
        tick(5);
        chk("R9 held while masked", pend_flag, 1);
        glob_mask = 1'b0;
        #1;
        chk("R9 presented after unmask", core_req, 1);
        tick(0);
        ack_pulse();
        chk("R9 cleared after service", core_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule